// File: doc/BRIEF.md
# Rank Auto-Refresh Controller

This block keeps every row of one DRAM rank refreshed inside the retention period. A free-running interval timer adds one owed refresh on each expiry. An owed refresh is offered to the memory scheduler as a request, and a grant starts it. The scheduler may postpone refreshes until a fixed number are owed. At that point the controller starts the next refresh by itself, with no grant.

Each refresh covers a batch of rows in every bank at once, one row time after another. For the whole batch the rank is reported busy, and access grants to the rest of the system are blocked. A row pointer follows the row being refreshed. It wraps at the number of rows per bank, and a one-cycle pulse marks each completed pass over all rows. With the default geometry, a batch of 8 rows per bank at 10 cycles each gives a 320 ns busy window out of every 7.8 µs at 250 MHz.

Top module: `rank_refresh_ctrl`

## Requirements
- R1: After reset, refReq, busy, forceRef, passDone and owed are all 0, and rowAddr is 0.
- R2: The interval timer adds one to owed every INTERVAL cycles. The first addition takes effect after INTERVAL rising edges following reset release. refReq is high whenever owed is non-zero and busy is low.
- R3: When refReq and refGrant are both high in a cycle, busy is high in the next cycle, owed has dropped by one and refReq is low.
- R4: Once started, busy stays high for exactly BATCH*ROW_CYC consecutive cycles.
- R5: accGrant follows accReq while the block is idle. accGrant is 0 while busy is high, and also in the cycle in which a refresh starts.
- R6: rowAddr advances by one at the end of each row time, so it advances by BATCH per refresh. It wraps from BANK_ROWS-1 to 0.
- R7: passDone is high for one cycle, in the first cycle in which rowAddr reads 0 after a wrap.
- R8: owed saturates at MAX_OWED. forceRef is high when owed equals MAX_OWED, and a refresh then starts without refGrant: busy is high in the next cycle and owed has dropped to MAX_OWED-1.
- R9: refGrant while owed is 0 has no effect: busy stays low and rowAddr does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refGrant | input | 1 | Scheduler grant for the pending refresh |
| accReq | input | 1 | Normal access request from the scheduler |
| refReq | output | 1 | A refresh is owed and the rank is idle |
| forceRef | output | 1 | Postponement limit reached; refresh starts without grant |
| busy | output | 1 | Rank unavailable, refresh batch in progress |
| accGrant | output | 1 | Normal access allowed this cycle |
| owed | output | $clog2(MAX_OWED+1) | Number of refreshes owed |
| rowAddr | output | $clog2(BANK_ROWS) | Row currently being refreshed in every bank |
| passDone | output | 1 | One-cycle pulse when a full pass over all rows ends |

## Verification
refReq rises after INTERVAL edges counted from reset release. After a grant edge, busy and the lowered owed count are visible one edge later. accGrant is combinational and is sampled in the same cycle as its stimulus. The bench samples every output on the falling edge and counts edges from each stimulus. It checks both sides of the first-request boundary, counts busy cycles one by one, and reads rowAddr after each batch is complete. A monitor running every cycle tracks busy rising edges and passDone pulses, so the pass count and the final row pointer are derived from refreshes actually seen at the ports.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef struct packed {
    logic start;
    logic rowStep;
  } ctl_strobes_t;
endpackage

// File: rtl/refresh_ctl.sv
module refresh_ctl
  import refresh_pkg::*;
#(
  parameter int INTERVAL = 1950,
  parameter int ROW_CYC  = 10,
  parameter int MAX_OWED = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic refGrant,
  input  logic accReq,
  input  logic lastRow,
  output logic refReq,
  output logic forceRef,
  output logic busy,
  output logic accGrant,
  output logic [$clog2(MAX_OWED+1)-1:0] owed,
  output ctl_strobes_t strobes
);
  localparam int TMR_W = $clog2(INTERVAL + 1);
  localparam int RC_W  = $clog2(ROW_CYC + 1);
  localparam int OW_W  = $clog2(MAX_OWED + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(INTERVAL - 1);
  localparam logic [RC_W-1:0]  RC_LAST  = RC_W'(ROW_CYC - 1);
  localparam logic [OW_W-1:0]  OW_MAX   = OW_W'(MAX_OWED);

  logic [TMR_W-1:0] tmr;
  logic [RC_W-1:0]  rowCnt;
  logic             busyQ;
  logic             tick;
  logic             startRef;
  logic             stepRow;
  logic             incOwed;

  always_comb begin
    tick     = (tmr == TMR_LAST);
    forceRef = (owed == OW_MAX);
    refReq   = (owed != '0) && !busyQ;
    startRef = refReq && (refGrant || forceRef);
    stepRow  = busyQ && (rowCnt == '0);
    incOwed  = tick && ((owed != OW_MAX) || startRef);
    accGrant = accReq && !busyQ && !startRef;
    busy     = busyQ;
    strobes.start   = startRef;
    strobes.rowStep = stepRow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmr <= '0;
    end else if (tick) begin
      tmr <= '0;
    end else begin
      tmr <= tmr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      owed <= '0;
    end else begin
      case ({incOwed, startRef})
        2'b10:   owed <= owed + 1'b1;
        2'b01:   owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      rowCnt <= '0;
    end else if (startRef) begin
      busyQ  <= 1'b1;
      rowCnt <= RC_LAST;
    end else if (stepRow) begin
      rowCnt <= RC_LAST;
      if (lastRow) busyQ <= 1'b0;
    end else if (busyQ) begin
      rowCnt <= rowCnt - 1'b1;
    end
  end
endmodule

// File: rtl/refresh_dp.sv
module refresh_dp
  import refresh_pkg::*;
#(
  parameter int BATCH     = 8,
  parameter int BANK_ROWS = 65536
) (
  input  logic clk,
  input  logic rstN,
  input  ctl_strobes_t strobes,
  output logic lastRow,
  output logic [$clog2(BANK_ROWS)-1:0] rowAddr,
  output logic passDone
);
  localparam int ROW_W = $clog2(BANK_ROWS);
  localparam int IDX_W = $clog2(BATCH + 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(BANK_ROWS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BATCH - 1);

  logic [IDX_W-1:0] batchIdx;

  assign lastRow = (batchIdx == IDX_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      batchIdx <= '0;
    end else if (strobes.start) begin
      batchIdx <= '0;
    end else if (strobes.rowStep) begin
      batchIdx <= batchIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowAddr  <= '0;
      passDone <= 1'b0;
    end else begin
      passDone <= strobes.rowStep && (rowAddr == ROW_LAST);
      if (strobes.rowStep) begin
        rowAddr <= (rowAddr == ROW_LAST) ? '0 : rowAddr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rank_refresh_ctrl.sv
module rank_refresh_ctrl
  import refresh_pkg::*;
#(
  parameter int INTERVAL  = 1950,
  parameter int BATCH     = 8,
  parameter int ROW_CYC   = 10,
  parameter int BANK_ROWS = 65536,
  parameter int MAX_OWED  = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic refGrant,
  input  logic accReq,
  output logic refReq,
  output logic forceRef,
  output logic busy,
  output logic accGrant,
  output logic [$clog2(MAX_OWED+1)-1:0] owed,
  output logic [$clog2(BANK_ROWS)-1:0] rowAddr,
  output logic passDone
);
  ctl_strobes_t strobes;
  logic         lastRow;

  refresh_ctl #(
    .INTERVAL(INTERVAL), .ROW_CYC(ROW_CYC), .MAX_OWED(MAX_OWED)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .accReq(accReq),
    .lastRow(lastRow), .refReq(refReq), .forceRef(forceRef), .busy(busy),
    .accGrant(accGrant), .owed(owed), .strobes(strobes)
  );

  refresh_dp #(
    .BATCH(BATCH), .BANK_ROWS(BANK_ROWS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .lastRow(lastRow),
    .rowAddr(rowAddr), .passDone(passDone)
  );
endmodule

// File: rtl/refresh_chk.sv
module refresh_chk #(
  parameter int MAX_OWED = 8,
  parameter int OWED_W   = 4,
  parameter int ROW_W    = 16
) (
  input logic clk,
  input logic rstN,
  input logic refReq,
  input logic refGrant,
  input logic forceRef,
  input logic busy,
  input logic accGrant,
  input logic [OWED_W-1:0] owed,
  input logic [ROW_W-1:0] rowAddr,
  input logic passDone
);
  // R5
  no_acc_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !accGrant);
  // R3
  grant_starts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && refGrant) |=> busy);
  // R8
  forced_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (forceRef && !busy) |=> busy);
  // R8
  owed_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    owed <= OWED_W'(MAX_OWED));
  // R7
  pass_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    passDone |-> (rowAddr == '0));
  // R7
  pass_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    passDone |=> !passDone);
  // R9
  idle_no_owed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (owed == '0 && !busy) |=> !busy);
endmodule

bind rank_refresh_ctrl refresh_chk #(
  .MAX_OWED(MAX_OWED), .OWED_W($clog2(MAX_OWED+1)), .ROW_W($clog2(BANK_ROWS))
) u_chk (
  .clk(clk), .rstN(rstN), .refReq(refReq), .refGrant(refGrant),
  .forceRef(forceRef), .busy(busy), .accGrant(accGrant), .owed(owed),
  .rowAddr(rowAddr), .passDone(passDone)
);

// File: tb/rank_refresh_ctrl_bench.sv
`timescale 1ns/1ps
module rank_refresh_ctrl_bench;
  localparam int INTERVAL  = 40;
  localparam int BATCH     = 4;
  localparam int ROW_CYC   = 3;
  localparam int BANK_ROWS = 16;
  localparam int MAX_OWED  = 8;
  localparam int BUSY_CYC  = BATCH * ROW_CYC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refGrant = 1'b0;
  logic accReq = 1'b0;
  logic refReq, forceRef, busy, accGrant, passDone;
  logic [3:0] owed;
  logic [3:0] rowAddr;

  int compared = 0;
  int mismatched = 0;
  int refCount = 0;
  int passCount = 0;
  int cycles = 0;
  logic prevBusy = 1'b0;

  always #2 clk = ~clk;

  rank_refresh_ctrl #(
    .INTERVAL(INTERVAL), .BATCH(BATCH), .ROW_CYC(ROW_CYC),
    .BANK_ROWS(BANK_ROWS), .MAX_OWED(MAX_OWED)
  ) u_rank_refresh_ctrl (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .accReq(accReq),
    .refReq(refReq), .forceRef(forceRef), .busy(busy), .accGrant(accGrant),
    .owed(owed), .rowAddr(rowAddr), .passDone(passDone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      if (busy && !prevBusy) refCount++;
      if (passDone) begin
        passCount++;
        if (rowAddr != 4'd0) check(1'b0, "R7", "rowAddr at passDone", rowAddr, 0);
      end
      if (busy && accGrant) check(1'b0, "R5", "accGrant while busy", 1, 0);
      prevBusy = busy;
    end
    if (cycles > 20000) begin
      check(1'b0, "R2", "watchdog expired", cycles, 20000);
      finish_run();
    end
  end

  task automatic wait_busy_end(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_and_idle_grant();
    @(negedge clk);
    check(refReq == 0 && busy == 0 && forceRef == 0 && passDone == 0, "R1",
          "control outputs at reset", {refReq, busy, forceRef, passDone}, 0);
    check(owed == 0 && rowAddr == 0, "R1", "owed/rowAddr at reset", owed + rowAddr, 0);
    rstN = 1'b1;
    refGrant = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (busy) check(1'b0, "R9", "busy from grant with nothing owed", 1, 0);
    end
    refGrant = 1'b0;
    check(rowAddr == 0 && busy == 0, "R9", "rowAddr after idle grant", rowAddr, 0);
    repeat (INTERVAL - 1 - 10) @(negedge clk);
    check(refReq == 0, "R2", "refReq one edge before interval", refReq, 0);
    @(negedge clk);
    check(refReq == 1 && owed == 1, "R2", "refReq/owed at interval", owed, 1);
  endtask

  task automatic t_granted_refresh();
    int n;
    accReq = 1'b1;
    #0.1;
    check(accGrant == 1, "R5", "accGrant while idle", accGrant, 1);
    refGrant = 1'b1;
    #0.1;
    check(accGrant == 0, "R5", "accGrant in start cycle", accGrant, 0);
    @(negedge clk);
    refGrant = 1'b0;
    check(busy == 1 && refReq == 0, "R3", "busy after grant", busy, 1);
    check(owed == 0, "R3", "owed after grant", owed, 0);
    check(accGrant == 0, "R5", "accGrant while busy", accGrant, 0);
    wait_busy_end(n);
    check(n == BUSY_CYC, "R4", "busy cycle count", n, BUSY_CYC);
    check(rowAddr == BATCH, "R6", "rowAddr after one batch", rowAddr, BATCH);
    check(accGrant == 1, "R5", "accGrant after busy", accGrant, 1);
    accReq = 1'b0;
  endtask

  task automatic t_forced_refresh();
    int n;
    int guard = 0;
    while (owed != MAX_OWED[3:0] && guard < 2000) begin
      guard++;
      @(negedge clk);
      if (owed == 3) check(forceRef == 0 && refReq == 1, "R8", "forceRef below limit", forceRef, 0);
    end
    check(forceRef == 1 && busy == 0, "R8", "forceRef at limit", forceRef, 1);
    @(negedge clk);
    check(busy == 1 && owed == MAX_OWED - 1, "R8", "owed after forced start", owed, MAX_OWED - 1);
    wait_busy_end(n);
    check(n == BUSY_CYC, "R4", "forced busy cycle count", n, BUSY_CYC);
    check(rowAddr == 2 * BATCH, "R6", "rowAddr after forced batch", rowAddr, 2 * BATCH);
  endtask

  task automatic t_drain_and_wrap();
    int guard = 0;
    refGrant = 1'b1;
    while ((owed != 0 || busy) && guard < 5000) begin
      guard++;
      @(negedge clk);
    end
    refGrant = 1'b0;
    @(negedge clk);
    check(owed == 0 && refReq == 0, "R3", "owed drained", owed, 0);
    check(rowAddr == (refCount * BATCH) % BANK_ROWS, "R6", "rowAddr after wraps",
          rowAddr, (refCount * BATCH) % BANK_ROWS);
    check(passCount == (refCount * BATCH) / BANK_ROWS, "R7", "pass pulse count",
          passCount, (refCount * BATCH) / BANK_ROWS);
    check(passCount >= 1, "R7", "at least one pass seen", passCount, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset_and_idle_grant();
    t_granted_refresh();
    t_forced_refresh();
    t_drain_and_wrap();
    finish_run();
  end
endmodule